// File: doc/BRIEF.md
# External Memory Write Sequencer

This block turns a single internal write request into a complete write cycle on an asynchronous external memory port. It drives the active-low region selects, the address, the active-low write strobe, the write data and the enable for the data bus. The block runs on a clock at twice the port clock, so each internal cycle is half a port-clock period. This lets the select and strobe edges sit half a port cycle apart.

Each of the memory regions has its own configuration. It holds a wait-state count that lengthens the strobe, a bit that makes the cycle wait for the external acknowledge input, and a write-hold bit that keeps data on the bus longer after the strobe rises. The configuration is captured when the request is accepted. There are three ways to stretch a cycle: wait states alone, acknowledge alone, or the two together. In the combined mode the acknowledge input is examined only after the programmed count has run out. After every cycle the block keeps the port idle for a fixed turnaround gap before it accepts the next request.

Top module: `xm_write_seq`

## Requirements
- R1: While reset is low and just after it is released, `wr_n` is 1, every bit of `mem_sel_n` is 1, `data_oe` is 0, `done` is 0 and `req_ready` is 1.
- R2: A request is accepted at the clock edge where `req_valid` and `req_ready` are both high. In the next cycle, which is the setup cycle, exactly one bit `mem_sel_n[k]` is driven to 0, where k is `req_region`, and `addr_o` carries the request address. In that same cycle `wr_n` stays 1 and `data_oe` stays 0. `wr_n` falls in the following cycle.
- R3: When a region's acknowledge bit is 0, `wr_n` stays low for exactly 2*(1+W) clock cycles. W is that region's 3-bit wait field `cfg_wait[3k+2:3k]`.
- R4: When a region's acknowledge bit `cfg_ack_en[k]` is 0, the value of `ack_i` has no effect on the strobe length.
- R5: In acknowledge mode, strobe cycles are numbered from 0, and 0 is the first cycle with `wr_n` low. `ack_i` is sampled on the edge that enters each even strobe cycle e ≥ 2W. A low sample keeps the strobe low until the next sample two cycles later. A high sample entering cycle e makes the strobe low for exactly e+4 cycles, which is two port cycles after the sample.
- R6: In combined mode (W>0 and acknowledge on), `ack_i` values before strobe cycle 2W are ignored. A strobe whose acknowledge is low only during that window is exactly 2W+4 cycles long.
- R7: `data_oe` rises in the same cycle that `wr_n` falls. `data_o` equals the request data while `wr_n` is low.
- R8: The cycle after `wr_n` rises keeps the region select low and keeps the address. The select is released one cycle later. `data_oe` stays high for 1 cycle after `wr_n` rises when the write-hold bit `cfg_hold[k]` is 0, and for 3 cycles when it is 1.
- R9: `done` is a one-cycle pulse in the first cycle in which all selects and `data_oe` are released.
- R10: `req_ready` is low for TURN_H cycles starting with the `done` cycle. A request that arrives in that window stalls until the window ends. Back-to-back writes without write hold have exactly 3+TURN_H cycles with `wr_n` high between strobes. TURN_H defaults to 2.
- R11: `req_ready` is low from the setup cycle until the end of the turnaround gap, so no second request is taken during a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the port clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wait | input | NREG*WSW | Wait count per region, region k at bits [k*WSW +: WSW] |
| cfg_hold | input | NREG | Write-hold bit per region |
| cfg_ack_en | input | NREG | Acknowledge-mode bit per region |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_region | input | RSW | Target region index |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| ack_i | input | 1 | External acknowledge, high = ready |
| mem_sel_n | output | NREG | Active-low region selects |
| addr_o | output | AW | Port address |
| wr_n | output | 1 | Active-low write strobe |
| data_o | output | DW | Port write data |
| data_oe | output | 1 | Data bus drive enable |
| done | output | 1 | One-cycle pulse when the bus is released |

## Verification
The hardest situation to reach is the combined mode, where acknowledge activity inside the wait-count window must be ignored and only the samples on even cycles after it count. To get there, the bench schedules `ack_i` relative to the strobe cycle index and changes it in the middle of each cycle. It holds acknowledge low through the count window and then raises it just before, exactly on, or after a sample point, and predicts the strobe length from the first even sample cycle that sees it high. A second case that is hard to reach is a request arriving inside the turnaround gap. The bench reaches it by issuing the next write as soon as the `done` pulse is observed.

// File: rtl/xm_write_pkg.sv
package xm_write_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_REL,
      ST_HOLD,
      ST_GAP
   } xm_state_e;
endpackage

// File: rtl/xm_region_cfg.sv
// Selects one region's configuration and decodes the region index to a one-hot select.
module xm_region_cfg #(
   parameter int NREG = 4,
   parameter int WSW  = 3,
   parameter int RSW  = 2
) (
   input  logic [NREG*WSW-1:0] cfg_wait,
   input  logic [NREG-1:0]     cfg_hold,
   input  logic [NREG-1:0]     cfg_ack_en,
   input  logic [RSW-1:0]      region,
   output logic [WSW-1:0]      wait_o,
   output logic                hold_o,
   output logic                ack_en_o,
   output logic [NREG-1:0]     sel_onehot
);
   logic [WSW-1:0] wait_arr [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      assign wait_arr[i]   = cfg_wait[i*WSW +: WSW];
      assign sel_onehot[i] = (region == RSW'(i));
   end

   assign wait_o   = wait_arr[region];
   assign hold_o   = cfg_hold[region];
   assign ack_en_o = cfg_ack_en[region];
endmodule

// File: rtl/xm_strobe_timer.sv
// Times the low phase of the write strobe, including wait states and acknowledge sampling.
module xm_strobe_timer #(
   parameter int WSW         = 3,
   parameter bit ACK_SUPPORT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           tick,
   input  logic [WSW-1:0] wait_cnt,
   input  logic           ack_en,
   input  logic           ack_i,
   output logic           last
);
   localparam int CW = WSW + 2;

   logic [CW-1:0] cnt_q;
   logic          await_q;
   logic [CW-1:0] base_fixed;

   // 2W+1: remaining cycles after the first strobe cycle, no acknowledge
   assign base_fixed = {1'b0, wait_cnt, 1'b1};

   if (ACK_SUPPORT) begin : g_ack
      logic [CW-1:0] base_ack;
      // 2W-1: count down to the first sample point at strobe cycle 2W
      assign base_ack = {1'b0, wait_cnt, 1'b0} - CW'(1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q   <= '0;
            await_q <= 1'b0;
         end else if (load) begin
            if (ack_en) begin
               if (wait_cnt == '0) begin
                  await_q <= !ack_i;
                  cnt_q   <= ack_i ? CW'(3) : CW'(1);
               end else begin
                  await_q <= 1'b1;
                  cnt_q   <= base_ack;
               end
            end else begin
               await_q <= 1'b0;
               cnt_q   <= base_fixed;
            end
         end else if (tick) begin
            if (cnt_q != '0) begin
               cnt_q <= cnt_q - CW'(1);
            end else if (await_q) begin
               if (ack_i) begin
                  cnt_q   <= CW'(3);
                  await_q <= 1'b0;
               end else begin
                  cnt_q <= CW'(1);
               end
            end
         end
      end
   end else begin : g_noack
      logic unused_ack;
      assign unused_ack = ack_en ^ ack_i;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (load) begin
            cnt_q <= base_fixed;
         end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
         end
      end
      assign await_q = 1'b0;
   end

   assign last = (cnt_q == '0) && !await_q;
endmodule

// File: rtl/xm_phase_cnt.sv
// Small loadable down counter that times the release, hold and turnaround phases.
module xm_phase_cnt #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          dec,
   output logic          zero
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec && cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/xm_write_seq.sv
module xm_write_seq #(
   parameter int AW          = 16,
   parameter int DW          = 16,
   parameter int NREG        = 4,
   parameter int WSW         = 3,
   parameter int TURN_H      = 2,
   parameter bit ACK_SUPPORT = 1'b1,
   parameter int RSW         = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NREG*WSW-1:0] cfg_wait,
   input  logic [NREG-1:0]     cfg_hold,
   input  logic [NREG-1:0]     cfg_ack_en,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [RSW-1:0]      req_region,
   input  logic [AW-1:0]       req_addr,
   input  logic [DW-1:0]       req_data,
   input  logic                ack_i,
   output logic [NREG-1:0]     mem_sel_n,
   output logic [AW-1:0]       addr_o,
   output logic                wr_n,
   output logic [DW-1:0]       data_o,
   output logic                data_oe,
   output logic                done
);
   import xm_write_pkg::*;

   localparam int PCW = $clog2(TURN_H + 2);

   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_chk_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (RSW != $clog2(NREG)) begin : g_chk_rsw
      $error("RSW must equal clog2(NREG)");
   end
   if (WSW < 1 || WSW > 8) begin : g_chk_wsw
      $error("WSW must lie in 1..8");
   end
   if (TURN_H < 1) begin : g_chk_turn
      $error("TURN_H must be at least 1");
   end
   if (AW < 1 || DW < 1) begin : g_chk_bus
      $error("bus widths must be positive");
   end

   xm_state_e      state_q, state_d;
   logic [AW-1:0]  addr_q;
   logic [DW-1:0]  data_q;
   logic [NREG-1:0] sel_q;
   logic [WSW-1:0] wait_q;
   logic           hold_q, ack_en_q, done_q;

   logic [WSW-1:0]  cfg_w;
   logic            cfg_h, cfg_a;
   logic [NREG-1:0] cfg_sel;
   logic            accept, strobe_last, ph_zero, ph_load;
   logic [PCW-1:0]  ph_val;

   xm_region_cfg #(.NREG(NREG), .WSW(WSW), .RSW(RSW)) u_cfg (
      .cfg_wait   (cfg_wait),
      .cfg_hold   (cfg_hold),
      .cfg_ack_en (cfg_ack_en),
      .region     (req_region),
      .wait_o     (cfg_w),
      .hold_o     (cfg_h),
      .ack_en_o   (cfg_a),
      .sel_onehot (cfg_sel)
   );

   xm_strobe_timer #(.WSW(WSW), .ACK_SUPPORT(ACK_SUPPORT)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (state_q == ST_SETUP),
      .tick     (state_q == ST_STROBE),
      .wait_cnt (wait_q),
      .ack_en   (ack_en_q),
      .ack_i    (ack_i),
      .last     (strobe_last)
   );

   assign ph_load = (state_q == ST_REL) || (state_q == ST_HOLD && ph_zero);
   assign ph_val  = (state_q == ST_REL && hold_q) ? PCW'(1) : PCW'(TURN_H - 1);

   xm_phase_cnt #(.CW(PCW)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ph_load),
      .load_val (ph_val),
      .dec      (state_q == ST_HOLD || state_q == ST_GAP),
      .zero     (ph_zero)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (accept) state_d = ST_SETUP;
         ST_SETUP:  state_d = ST_STROBE;
         ST_STROBE: if (strobe_last) state_d = ST_REL;
         ST_REL:    state_d = hold_q ? ST_HOLD : ST_GAP;
         ST_HOLD:   if (ph_zero) state_d = ST_GAP;
         ST_GAP:    if (ph_zero) state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         done_q   <= 1'b0;
      end else begin
         state_q  <= state_d;
         done_q   <= (state_d == ST_GAP) && (state_q != ST_GAP);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         data_q   <= '0;
         sel_q    <= '0;
         wait_q   <= '0;
         hold_q   <= 1'b0;
         ack_en_q <= 1'b0;
      end else if (accept) begin
         addr_q   <= req_addr;
         data_q   <= req_data;
         sel_q    <= cfg_sel;
         wait_q   <= cfg_w;
         hold_q   <= cfg_h;
         ack_en_q <= cfg_a;
      end
   end

   assign mem_sel_n = (state_q == ST_SETUP || state_q == ST_STROBE || state_q == ST_REL)
                      ? ~sel_q : '1;
   assign wr_n      = (state_q != ST_STROBE);
   assign data_oe   = (state_q == ST_STROBE || state_q == ST_REL || state_q == ST_HOLD);
   assign addr_o    = addr_q;
   assign data_o    = data_q;
   assign done      = done_q;
endmodule

// File: rtl/xm_write_seq_chk.sv
module xm_write_seq_chk #(
   parameter int AW   = 16,
   parameter int NREG = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic [NREG-1:0] mem_sel_n,
   input logic [AW-1:0]   addr_o,
   input logic            wr_n,
   input logic            data_oe,
   input logic            done
);
   // R2: at most one region selected at any time
   p_one_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mem_sel_n));

   // R2: strobe falls only after a setup cycle with a region selected
   p_setup_before_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n) |-> $past(mem_sel_n) != '1);

   // R2: address does not move while a region stays selected
   p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_sel_n != '1 && $past(mem_sel_n) != '1) |-> $stable(addr_o));

   // R3: a strobe lasts at least two cycles
   p_min_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_n) |=> !wr_n);

   // R7: data driven whenever the strobe is low
   p_oe_with_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> data_oe && $countones(~mem_sel_n) == 1);

   // R8: select still held in the cycle the strobe rises
   p_sel_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_n) |-> mem_sel_n != '1 && data_oe);

   // R9: done is a single-cycle pulse with the bus released
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> mem_sel_n == '1 && !data_oe && wr_n && !req_ready);

   // R11: ready only with the port fully idle
   p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> wr_n && mem_sel_n == '1 && !data_oe);
endmodule

bind xm_write_seq xm_write_seq_chk #(.AW(AW), .NREG(NREG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .mem_sel_n (mem_sel_n),
   .addr_o    (addr_o),
   .wr_n      (wr_n),
   .data_oe   (data_oe),
   .done      (done)
);

// File: tb/sim_xm_write_seq.sv
module sim_xm_write_seq;
   localparam int AW = 16, DW = 16, NREG = 4, WSW = 3, TURN_H = 2, RSW = 2;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NREG*WSW-1:0] cfg_wait;
   logic [NREG-1:0]     cfg_hold, cfg_ack_en;
   logic                req_valid = 1'b0;
   logic                req_ready;
   logic [RSW-1:0]      req_region = '0;
   logic [AW-1:0]       req_addr = '0;
   logic [DW-1:0]       req_data = '0;
   logic                ack_i = 1'b0;
   logic [NREG-1:0]     mem_sel_n;
   logic [AW-1:0]       addr_o;
   logic                wr_n;
   logic [DW-1:0]       data_o;
   logic                data_oe;
   logic                done;

   int nchk = 0, nfail = 0;
   int w_cfg [NREG];
   bit h_cfg [NREG];
   bit a_cfg [NREG];
   int cyc = 0, rise_cyc = -1000, last_gap = -1, stall = 0;
   logic wr_prev = 1'b1;

   always #10 clk = ~clk;

   xm_write_seq #(.AW(AW), .DW(DW), .NREG(NREG), .WSW(WSW), .TURN_H(TURN_H)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
      .cfg_ack_en(cfg_ack_en), .req_valid(req_valid), .req_ready(req_ready),
      .req_region(req_region), .req_addr(req_addr), .req_data(req_data),
      .ack_i(ack_i), .mem_sel_n(mem_sel_n), .addr_o(addr_o), .wr_n(wr_n),
      .data_o(data_o), .data_oe(data_oe), .done(done)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (!wr_prev && wr_n) rise_cyc = cyc;
      if (wr_prev && !wr_n) last_gap = cyc - rise_cyc;
      wr_prev = wr_n;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic apply_cfg();
      for (int i = 0; i < NREG; i++) begin
         cfg_wait[i*WSW +: WSW] = WSW'(w_cfg[i]);
         cfg_hold[i]            = h_cfg[i];
         cfg_ack_en[i]          = a_cfg[i];
      end
   endtask

   function automatic int first_sample(input int w, input int c0);
      int e = 2 * w;
      if (e < c0 + 1) e = c0 + 1;
      if (e % 2 != 0) e++;
      return e;
   endfunction

   // One write; ack_i is high in every strobe-relative cycle c >= c0 (setup cycle is c=-1)
   task automatic do_write(input int rg, input int addr, input int data,
                           input int c0, input string req);
      logic t_wr [0:255];
      logic t_oe [0:255];
      logic t_dn [0:255];
      logic t_rdy [0:255];
      logic [NREG-1:0] t_sel [0:255];
      bit t_dat [0:255];
      int n_exp, c, n, oe_last, done_at;
      logic [NREG-1:0] sel_exp;
      n_exp   = a_cfg[rg] ? first_sample(w_cfg[rg], c0) + 4 : 2 * (1 + w_cfg[rg]);
      sel_exp = ~(NREG'(1) << rg);
      @(negedge clk);
      req_valid  = 1'b1;
      req_region = RSW'(rg);
      req_addr   = AW'(addr);
      req_data   = DW'(data);
      ack_i      = (c0 <= -2);
      stall      = 0;
      while (!req_ready) begin
         stall++;
         @(negedge clk);
      end
      c = -1;
      done_at = -100;
      while (c < 250 && done_at < 0) begin
         @(negedge clk);
         req_valid     = 1'b0;
         t_wr[c+1]     = wr_n;
         t_oe[c+1]     = data_oe;
         t_dn[c+1]     = done;
         t_rdy[c+1]    = req_ready;
         t_sel[c+1]    = mem_sel_n;
         t_dat[c+1]    = (data_o == DW'(data));
         if (c == -1) chk(addr_o == AW'(addr), "R2", "address in setup", int'(addr_o), addr);
         if (done) done_at = c;
         ack_i = (c >= c0);
         c++;
      end
      chk(done_at >= 0, "R9", "done seen", done_at, 0);
      chk(t_sel[0] == sel_exp && t_wr[0] && !t_oe[0], "R2", "setup cycle select",
          int'(t_sel[0]), int'(sel_exp));
      chk(!t_rdy[0], "R11", "ready low in setup", int'(t_rdy[0]), 0);
      n = 0;
      while (n < 200 && !t_wr[n+1]) n++;
      chk(n == n_exp, req, "strobe length", n, n_exp);
      chk(t_oe[1] && !t_wr[1], "R7", "oe with strobe fall", int'(t_oe[1]), 1);
      chk(t_dat[1] && t_dat[n], "R7", "data during strobe", int'(t_dat[1]), 1);
      chk(t_sel[n+1] == sel_exp && t_sel[n+2] == '1, "R8", "select hold after strobe",
          int'(t_sel[n+2]), int'({NREG{1'b1}}));
      oe_last = n;
      while (oe_last < 240 && t_oe[oe_last+1]) oe_last++;
      chk(oe_last - n == (h_cfg[rg] ? 3 : 1), "R8", "oe hold after strobe",
          oe_last - n, h_cfg[rg] ? 3 : 1);
      chk(done_at == n + 1 + (h_cfg[rg] ? 2 : 0), "R9", "done position",
          done_at, n + 1 + (h_cfg[rg] ? 2 : 0));
      ack_i = 1'b0;
   endtask

   task automatic t_reset();
      #5;
      chk(wr_n && mem_sel_n == '1 && !data_oe && !done && req_ready, "R1",
          "outputs in reset", int'({wr_n, data_oe, done, req_ready}), 4'b1001);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wr_n && mem_sel_n == '1 && !data_oe && !done && req_ready, "R1",
          "outputs after reset", int'({wr_n, data_oe, done, req_ready}), 4'b1001);
   endtask

   task automatic t_wait_only();
      do_write(0, 16'h1234, 16'hA5A5, 1000, "R3");
      w_cfg[0] = 0; apply_cfg();
      do_write(0, 16'h0042, 16'h5A5A, 1000, "R3");
      do_write(3, 16'hBEEF, 16'h0F0F, 1000, "R3");
      w_cfg[0] = 1; apply_cfg();
   endtask

   task automatic t_ack_ignored();
      // region 0 has acknowledge off: ack_i low throughout, then high throughout
      do_write(0, 16'h0100, 16'h1111, 1000, "R4");
      do_write(0, 16'h0101, 16'h2222, -1, "R4");
   endtask

   task automatic t_ack_only();
      do_write(2, 16'h0200, 16'h3333, -1, "R5");
      do_write(2, 16'h0201, 16'h4444, 3, "R5");
      do_write(2, 16'h0202, 16'h5555, 4, "R5");
   endtask

   task automatic t_combined();
      do_write(1, 16'h0300, 16'h6666, -1, "R6");
      do_write(1, 16'h0301, 16'h7777, 3, "R6");
      do_write(1, 16'h0302, 16'h8888, 7, "R5");
   endtask

   task automatic t_back_to_back();
      do_write(0, 16'h0400, 16'h9999, 1000, "R3");
      do_write(0, 16'h0401, 16'hAAAA, 1000, "R3");
      chk(stall == TURN_H - 1, "R10", "stall during gap", stall, TURN_H - 1);
      chk(last_gap == 3 + TURN_H, "R10", "strobe spacing", last_gap, 3 + TURN_H);
   endtask

   initial begin
      w_cfg[0] = 1; h_cfg[0] = 0; a_cfg[0] = 0;
      w_cfg[1] = 2; h_cfg[1] = 0; a_cfg[1] = 1;
      w_cfg[2] = 0; h_cfg[2] = 1; a_cfg[2] = 1;
      w_cfg[3] = 7; h_cfg[3] = 1; a_cfg[3] = 0;
      apply_cfg();
      t_reset();
      t_wait_only();
      t_ack_ignored();
      t_ack_only();
      t_combined();
      t_back_to_back();
      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule